// File: doc/BRIEF.md
# Segment Translation and Protection Checker

This block turns a segmented virtual address, a segment number paired with a displacement, into a real address. For each accepted request it computes the address of the segment's map entry as the table base plus the segment number. It fetches that entry through a single-outstanding memory read port. It then judges the entry against the request and returns either the translated address or one coded exception.

The entry tells the checker four things: whether the segment is present in main memory, where it starts, how long it is, and which kinds of access it permits. The permitted kinds are read, write, execute and append. Three faults are possible. They are judged in a fixed order, and only the first that applies is reported. A present, in-bounds, permitted access yields the segment start plus the displacement. Handling of faults and sharing of segments belong to software above this block.

Top module: `seg_xlate`

## Requirements
- R1: While rst_ni is low and after its release, done_o, mem_req_o and addr_valid_o are 0, exc_o is 0 and real_addr_o is 0 until the first completion.
- R2: A request accepted in idle (req_valid_i high at a clock edge) raises mem_req_o for exactly one cycle, starting one cycle later, with mem_addr_o equal to tbl_base_i plus the zero-extended seg_i, modulo 2^32.
- R3: done_o is a one-cycle pulse, high in the cycle right after the edge at which mem_rvalid_i is sampled high while waiting. It is low in every cycle before that.
- R4: The entry layout is base in bits [31:0], length in bits [47:32], resident in bit 48, and permission bits 49 (read), 50 (write), 51 (execute) and 52 (append). If the resident bit is 0, exc_o is 1 (missing), whatever the length and permissions.
- R5: If the segment is resident and the displacement is greater than the length, exc_o is 2 (overflow). A displacement equal to the length is in bounds.
- R6: The access codes are 0 read, 1 write, 2 execute and 3 append. If the segment is resident and in bounds but the permission bit for the access code is 0, exc_o is 3 (protection).
- R7: If no fault applies, exc_o is 0, addr_valid_o is 1 and real_addr_o equals the entry base plus the zero-extended displacement, modulo 2^32.
- R8: Whenever exc_o is nonzero, addr_valid_o is 0 and real_addr_o is 0.
- R9: req_valid_i is ignored while a translation is in flight. It issues no memory read, and it neither changes nor queues a result.
- R10: real_addr_o, addr_valid_o and exc_o hold their values from one completion until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_seg_i | input | 16 | Segment number |
| req_disp_i | input | 16 | Displacement within segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 append |
| tbl_base_i | input | 32 | Segment map table base address |
| mem_req_o | output | 1 | Entry read strobe |
| mem_addr_o | output | 32 | Entry address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 53 | Entry contents |
| done_o | output | 1 | Completion pulse |
| real_addr_o | output | 32 | Translated address |
| addr_valid_o | output | 1 | Translated address is usable |
| exc_o | output | 2 | 0 none, 1 missing, 2 overflow, 3 protection |

## Verification
The main sweep crosses residency, three displacements that sit one below, exactly at and one above the length, all sixteen permission patterns and all four access kinds. This shows that each fault masks the ones below it, and that the length comparison is strict at the boundary. Segment bases near the top of the address space, and a table base near its top, separate modular wrap in both adders from any carry into extra bits. Memory latencies of one to three cycles, and requests poked in mid-flight, separate a completion tied to the read data from one tied to a fixed delay or to a fresh request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned PERM_N = 4;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_EXEC   = 2'd2,
    ACC_APPEND = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_MISSING  = 2'd1,
    EXC_OVERFLOW = 2'd2,
    EXC_PROTECT  = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/seg_entry_unpack.sv
module seg_entry_unpack
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  localparam int unsigned ENTRY_W = ADDR_W + DISP_W + 1 + PERM_N
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [DISP_W-1:0]  len_o,
  output logic               resident_o,
  output logic [PERM_N-1:0]  perm_o
);
  localparam int unsigned LEN_LO = ADDR_W;
  localparam int unsigned RES_BIT = ADDR_W + DISP_W;
  localparam int unsigned PERM_LO = RES_BIT + 1;

  assign base_o     = entry_i[ADDR_W-1:0];
  assign len_o      = entry_i[LEN_LO +: DISP_W];
  assign resident_o = entry_i[RES_BIT];
  assign perm_o     = entry_i[PERM_LO +: PERM_N];
endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
  import seg_xlate_pkg::*;
#(
  parameter int unsigned DISP_W = 16
) (
  input  logic              resident_i,
  input  logic [DISP_W-1:0] len_i,
  input  logic [PERM_N-1:0] perm_i,
  input  logic [DISP_W-1:0] disp_i,
  input  acc_e              acc_i,
  output exc_e              exc_o
);
  logic over_len;
  logic denied;

  assign over_len = disp_i > len_i;

  // one permission bit per access kind, selected by code
  always_comb begin
    denied = 1'b1;
    for (int k = 0; k < int'(PERM_N); k++) begin
      if (acc_i == acc_e'(k)) denied = ~perm_i[k];
    end
  end

  // fixed priority: missing, then overflow, then protection
  always_comb begin
    if (!resident_i)   exc_o = EXC_MISSING;
    else if (over_len) exc_o = EXC_OVERFLOW;
    else if (denied)   exc_o = EXC_PROTECT;
    else               exc_o = EXC_NONE;
  end
endmodule

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
  import seg_xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rvalid_i,
  output logic accept_o,
  output logic issue_o,
  output logic land_o,
  output logic done_o
);
  xl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (rvalid_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign issue_o  = (state_q == ST_ISSUE);
  assign land_o   = (state_q == ST_WAIT) && rvalid_i;
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned ENTRY_W = ADDR_W + DISP_W + 1 + PERM_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [SEG_W-1:0]   req_seg_i,
  input  logic [DISP_W-1:0]  req_disp_i,
  input  logic [1:0]         req_acc_i,
  input  logic [ADDR_W-1:0]  tbl_base_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  real_addr_o,
  output logic               addr_valid_o,
  output logic [1:0]         exc_o
);
  logic accept, land;

  seg_xlate_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (req_valid_i),
    .rvalid_i (mem_rvalid_i),
    .accept_o (accept),
    .issue_o  (mem_req_o),
    .land_o   (land),
    .done_o   (done_o)
  );

  logic [DISP_W-1:0] disp_q;
  acc_e              acc_q;
  logic [ADDR_W-1:0] ent_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q     <= '0;
      acc_q      <= ACC_READ;
      ent_addr_q <= '0;
    end else if (accept) begin
      disp_q     <= req_disp_i;
      acc_q      <= acc_e'(req_acc_i);
      ent_addr_q <= tbl_base_i + ADDR_W'(req_seg_i);
    end
  end

  assign mem_addr_o = ent_addr_q;

  logic [ADDR_W-1:0] seg_base;
  logic [DISP_W-1:0] seg_len;
  logic              seg_res;
  logic [PERM_N-1:0] seg_perm;
  exc_e              exc_d;

  seg_entry_unpack #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_unpack (
    .entry_i    (mem_rdata_i),
    .base_o     (seg_base),
    .len_o      (seg_len),
    .resident_o (seg_res),
    .perm_o     (seg_perm)
  );

  seg_fault_eval #(.DISP_W(DISP_W)) u_fault (
    .resident_i (seg_res),
    .len_i      (seg_len),
    .perm_i     (seg_perm),
    .disp_i     (disp_q),
    .acc_i      (acc_q),
    .exc_o      (exc_d)
  );

  logic [ADDR_W-1:0] real_q;
  logic              ok_q;
  exc_e              exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      real_q <= '0;
      ok_q   <= 1'b0;
      exc_q  <= EXC_NONE;
    end else if (land) begin
      exc_q  <= exc_d;
      ok_q   <= (exc_d == EXC_NONE);
      real_q <= (exc_d == EXC_NONE) ? seg_base + ADDR_W'(disp_q) : '0;
    end
  end

  assign real_addr_o  = real_q;
  assign addr_valid_o = ok_q;
  assign exc_o        = exc_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              mem_req_o,
  input logic              mem_rvalid_i,
  input logic              done_o,
  input logic [ADDR_W-1:0] real_addr_o,
  input logic              addr_valid_o,
  input logic [1:0]        exc_o
);
  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_req_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(req_valid_i));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_rvalid_i));
  assert_no_req_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
  assert_no_addr_on_exc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o != 2'd0) |-> (!addr_valid_o && real_addr_o == '0));
  assert_hold_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_o) && !done_o |-> $stable(real_addr_o) && $stable(exc_o) && $stable(addr_valid_o));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .done_o       (done_o),
  .real_addr_o  (real_addr_o),
  .addr_valid_o (addr_valid_o),
  .exc_o        (exc_o)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int SEG_W = 16, DISP_W = 16, ADDR_W = 32;
  localparam int ENTRY_W = ADDR_W + DISP_W + 5;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [DISP_W-1:0] req_disp = '0;
  logic [1:0] req_acc = '0;
  logic [ADDR_W-1:0] tbl_base = '0;
  logic mem_req, mem_rvalid = 1'b0, done, addr_valid;
  logic [ADDR_W-1:0] mem_addr, real_addr;
  logic [ENTRY_W-1:0] mem_rdata = '0;
  logic [1:0] exc;

  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_seg_i(req_seg),
    .req_disp_i(req_disp), .req_acc_i(req_acc), .tbl_base_i(tbl_base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .real_addr_o(real_addr),
    .addr_valid_o(addr_valid), .exc_o(exc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mk_entry(input bit res, input logic [3:0] perm,
                                                  input logic [15:0] len, input logic [31:0] base);
    return {perm, res, len, base};
  endfunction

  // one full transaction; poke drives a stray request while in flight
  task automatic txn(input logic [15:0] seg, input logic [15:0] disp, input logic [1:0] acc,
                     input logic [31:0] tb, input bit res, input logic [3:0] perm,
                     input logic [15:0] len, input logic [31:0] sbase, input int lat, input bit poke);
    logic [1:0] e_exc;
    logic [31:0] e_addr;
    logic [31:0] e_ent;
    e_ent = tb + {16'h0, seg};
    if (!res) e_exc = 2'd1;
    else if (disp > len) e_exc = 2'd2;
    else if (!perm[acc]) e_exc = 2'd3;
    else e_exc = 2'd0;
    e_addr = (e_exc == 2'd0) ? sbase + {16'h0, disp} : 32'h0;

    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_disp = disp; req_acc = acc; tbl_base = tb;
    @(negedge clk);
    chk(mem_req === 1'b1, "R2 mem_req", mem_req, 1);
    chk(mem_addr === e_ent, "R2 mem_addr", mem_addr, e_ent);
    req_valid = poke; req_seg = ~seg; req_disp = ~disp; req_acc = ~acc;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(done === 1'b0, "R3 early done", done, 0);
      if (poke) chk(mem_req === 1'b0, "R9 busy req", mem_req, 0);
    end
    mem_rvalid = 1'b1;
    mem_rdata = mk_entry(res, perm, len, sbase);
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    req_valid = 1'b0;
    chk(done === 1'b1, "R3 done", done, 1);
    chk(exc === e_exc, e_exc == 1 ? "R4 exc" : e_exc == 2 ? "R5 exc" : e_exc == 3 ? "R6 exc" : "R7 exc",
        exc, e_exc);
    chk(real_addr === e_addr, e_exc == 0 ? "R7 real_addr" : "R8 real_addr", real_addr, e_addr);
    chk(addr_valid === (e_exc == 0), e_exc == 0 ? "R7 valid" : "R8 valid", addr_valid, e_exc == 0);
    @(negedge clk);
    chk(done === 1'b0, "R3 done width", done, 0);
    chk(mem_req === 1'b0, poke ? "R9 no queued req" : "R2 single req", mem_req, 0);
    chk(exc === e_exc && real_addr === e_addr, "R10 hold", {exc, real_addr}, {e_exc, e_addr});
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int idx;
    repeat (2) @(negedge clk);
    chk(done === 0 && mem_req === 0 && addr_valid === 0, "R1 in reset", {done, mem_req, addr_valid}, 0);
    chk(exc === 0 && real_addr === 0, "R1 in reset out", {exc, real_addr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done === 0 && mem_req === 0 && addr_valid === 0 && exc === 0 && real_addr === 0,
        "R1 after reset", {done, mem_req, addr_valid, exc}, 0);

    idx = 0;
    for (int r = 0; r < 2; r++)
      for (int ds = 0; ds < 3; ds++)
        for (int p = 0; p < 16; p++)
          for (int a = 0; a < 4; a++) begin
            logic [15:0] len, disp, seg;
            logic [31:0] sb, tb;
            len  = 16'h0100 + 16'(idx);
            disp = len + 16'(ds) - 16'd1;
            seg  = (idx % 7 == 0) ? 16'hFFFF : 16'(idx * 97);
            tb   = (idx % 3 == 0) ? 32'hFFFF_FFF0 : 32'h0001_0000 + 32'(idx * 16);
            sb   = (idx % 5 == 0) ? 32'hFFFF_FF80 : 32'(idx) * 32'h0001_0010;
            txn(seg, disp, 2'(a), tb, r[0], 4'(p), len, sb, 1 + idx % 3, idx % 4 == 1);
            idx++;
          end

    // length extremes
    txn(16'd3, 16'hFFFF, 2'd0, 32'h100, 1'b1, 4'hF, 16'hFFFF, 32'h8000_0000, 2, 1'b0); // R5 at max
    txn(16'd4, 16'h0000, 2'd3, 32'h100, 1'b1, 4'h8, 16'h0000, 32'h0000_1234, 1, 1'b0); // R5 zero len
    txn(16'd5, 16'h0001, 2'd1, 32'h100, 1'b1, 4'h0, 16'h0000, 32'h0000_1234, 1, 1'b1); // R5 over R6
    txn(16'd6, 16'hFFFF, 2'd2, 32'h100, 1'b0, 4'h0, 16'h0000, 32'h0000_1234, 3, 1'b0); // R4 over all

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule